// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block deserialises a two-channel serial audio stream. A data line carries the bits of each sample, most significant bit first. A word-select line marks which channel the current word belongs to, and an external bit clock paces both lines. The block runs on a faster system clock and oversamples the bit clock. It picks out the programmed sampling edge and shifts in a fixed number of bits after each word-select transition. Each finished word is presented as a parallel value with a channel tag and a one-cycle valid pulse.

Two control bits are written through a small write port and can be read back. The polarity bit chooses whether the lines are sampled on the rising or the falling edge of the bit clock. The alignment bit chooses whether a word-select change coincides with the first bit of the new word, or arrives one bit earlier together with the last bit of the previous word (the I2S arrangement). A write takes effect at the next word boundary, so a word that is being received is never corrupted by it. Both bits are cleared by the hardware reset and by the soft reset input.

Top module: `aud_ser_rx`

## Requirements
- R1: Hardware reset and the soft reset input both clear the two control bits (readback 0/0), `valid_o` and `err_o`; the soft reset also abandons any word in progress.
- R2: With polarity 0, word select and data are taken on the rising edge of `sclk_i`.
- R3: With polarity 1, word select and data are taken on the falling edge of `sclk_i`.
- R4: With alignment 0, the bit sampled together with a changed word-select level is the most significant bit of the new word.
- R5: With alignment 1, a changed word-select level arrives with the last bit of the previous word, and the new word starts on the next sampling edge.
- R6: The tag `right_o` is 0 for a word framed by word select low (left) and 1 for a word framed by word select high (right).
- R7: A word holds W bits (parameter, default 24, at least 2) received MSB first. Bits beyond W before the next word-select change are ignored.
- R8: A word-select change before W bits of the current word have arrived discards that word, with no valid pulse, and pulses `err_o` for one cycle.
- R9: `valid_o` is high for exactly one system-clock cycle per completed word, and `word_o` and `right_o` hold their values until the next pulse.
- R10: A control write is visible on the readback outputs in the next cycle. While words are being received, it alters sampling only after the next word boundary.
- R11: After reset no word is delivered until a first word-select change has been seen; the partial word before it produces neither output nor error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous active-high soft reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wpol | input | 1 | Polarity value to write (0 rising, 1 falling sampling edge) |
| cfg_wrel | input | 1 | Alignment value to write (0 same bit, 1 one bit early) |
| cfg_pol_o | output | 1 | Readback of the polarity bit |
| cfg_rel_o | output | 1 | Readback of the alignment bit |
| sclk_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | Word select (0 left, 1 right) |
| sd_i | input | 1 | Serial data, MSB first |
| word_o | output | W | Last completed word |
| right_o | output | 1 | Channel tag of `word_o` |
| valid_o | output | 1 | One-cycle pulse for a new word |
| err_o | output | 1 | One-cycle pulse for a truncated word |

## Verification
On every cycle the assertions check the single-cycle width of the valid pulse, that `word_o` and `right_o` hold between pulses, that an error pulse never coincides with a valid pulse, and that the readback follows each write and each soft reset. Which edge is sampled, how word select lines up with data, the channel tags, how short and long slots are handled, and the deferred application of control writes only show up in the words delivered. The bench scenarios drive complete frames in each mode and compare every delivered word and tag with values computed from the stream it sent.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

    // Receiver control: sampling polarity and word-select alignment
    typedef struct packed {
        logic pol;   // 0: sample on rising edge, 1: on falling edge
        logic rel;   // 0: word select with MSB, 1: one bit earlier
    } rx_cfg_t;

    // One sampling event from the edge detector
    typedef struct packed {
        logic stb;   // sampling edge seen this cycle
        logic ws;    // word-select level at that edge
        logic sd;    // data level at that edge
    } rx_smp_t;

    // Detect the programmed edge of the oversampled bit clock
    function automatic logic pick_edge(input logic pol, input logic cur, input logic prev);
        return pol ? (prev & ~cur) : (cur & ~prev);
    endfunction

    // Word-select level that frames the bit sampled now
    function automatic logic frame_level(input logic rel, input logic ws_now, input logic ws_old);
        return rel ? ws_old : ws_now;
    endfunction

endpackage

// File: rtl/aud_ser_rx_ctrl.sv
module aud_ser_rx_ctrl
    import aud_ser_rx_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    we,
    input  rx_cfg_t wcfg,
    input  logic    load,
    output rx_cfg_t shadow,
    output rx_cfg_t active
);
    // Written value is held in the shadow; the receiver uses the active
    // copy, refreshed only when the deserialiser signals a boundary.
    always_ff @(posedge clk) begin
        if (clr) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (we)
                shadow <= wcfg;
            if (load)
                active <= shadow;
        end
    end
endmodule

// File: rtl/aud_ser_rx_edge.sv
module aud_ser_rx_edge
    import aud_ser_rx_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    pol,
    input  logic    sclk_i,
    input  logic    ws_i,
    input  logic    sd_i,
    output rx_smp_t smp
);
    logic cap_sclk, cap_ws, cap_sd, old_sclk;

    always_ff @(posedge clk) begin
        if (clr) begin
            cap_sclk <= 1'b0;
            cap_ws   <= 1'b0;
            cap_sd   <= 1'b0;
            old_sclk <= 1'b0;
        end else begin
            cap_sclk <= sclk_i;
            cap_ws   <= ws_i;
            cap_sd   <= sd_i;
            old_sclk <= cap_sclk;
        end
    end

    always_comb begin
        smp.stb = pick_edge(pol, cap_sclk, old_sclk);
        smp.ws  = cap_ws;
        smp.sd  = cap_sd;
    end
endmodule

// File: rtl/aud_ser_rx_deser.sv
module aud_ser_rx_deser
    import aud_ser_rx_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         clr,
    input  rx_cfg_t      cfg,
    input  rx_smp_t      smp,
    output logic         load_o,
    output logic [W-1:0] word_o,
    output logic         right_o,
    output logic         valid_o,
    output logic         err_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          ws_old, have_old;    // word select at previous edge
    logic          fr_prev, have_fr;    // framing level at previous edge
    logic          locked;              // a first boundary has been seen
    logic          chan;                // framing level of word in progress
    logic [CW-1:0] cnt;                 // bits received of current word
    logic [W-1:0]  sh;

    logic          fr_ok, fr_ws, bnd;
    logic [W-1:0]  sh_nxt;

    always_comb begin
        fr_ok  = cfg.rel ? have_old : 1'b1;
        fr_ws  = frame_level(cfg.rel, smp.ws, ws_old);
        bnd    = smp.stb && fr_ok && have_fr && (fr_ws != fr_prev);
        sh_nxt = {sh[W-2:0], smp.sd};
        load_o = !locked || bnd;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ws_old   <= 1'b0;
            have_old <= 1'b0;
            fr_prev  <= 1'b0;
            have_fr  <= 1'b0;
            locked   <= 1'b0;
            chan     <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            word_o   <= '0;
            right_o  <= 1'b0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (smp.stb) begin
                ws_old   <= smp.ws;
                have_old <= 1'b1;
                if (fr_ok) begin
                    fr_prev <= fr_ws;
                    have_fr <= 1'b1;
                end
                if (bnd) begin
                    err_o  <= locked && (cnt < FULL);
                    sh     <= sh_nxt;
                    cnt    <= CW'(1);
                    chan   <= fr_ws;
                    locked <= 1'b1;
                end else if (locked && fr_ok && (cnt < FULL)) begin
                    sh  <= sh_nxt;
                    cnt <= cnt + CW'(1);
                    if (cnt == LAST) begin
                        word_o  <= sh_nxt;
                        right_o <= chan;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_ser_rx_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_rst,
    input  logic         cfg_we,
    input  logic         cfg_wpol,
    input  logic         cfg_wrel,
    output logic         cfg_pol_o,
    output logic         cfg_rel_o,
    input  logic         sclk_i,
    input  logic         ws_i,
    input  logic         sd_i,
    output logic [W-1:0] word_o,
    output logic         right_o,
    output logic         valid_o,
    output logic         err_o
);
    logic    clr, load;
    rx_cfg_t wcfg, shadow, active;
    rx_smp_t smp;

    assign clr       = rst | sw_rst;
    assign wcfg      = '{pol: cfg_wpol, rel: cfg_wrel};
    assign cfg_pol_o = shadow.pol;
    assign cfg_rel_o = shadow.rel;

    aud_ser_rx_ctrl u_ctrl (
        .clk    (clk),
        .clr    (clr),
        .we     (cfg_we),
        .wcfg   (wcfg),
        .load   (load),
        .shadow (shadow),
        .active (active)
    );

    aud_ser_rx_edge u_edge (
        .clk    (clk),
        .clr    (clr),
        .pol    (active.pol),
        .sclk_i (sclk_i),
        .ws_i   (ws_i),
        .sd_i   (sd_i),
        .smp    (smp)
    );

    aud_ser_rx_deser #(.W(W)) u_deser (
        .clk     (clk),
        .clr     (clr),
        .cfg     (active),
        .smp     (smp),
        .load_o  (load),
        .word_o  (word_o),
        .right_o (right_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         sw_rst,
    input logic         cfg_we,
    input logic         cfg_wpol,
    input logic         cfg_wrel,
    input logic         cfg_pol_o,
    input logic         cfg_rel_o,
    input logic [W-1:0] word_o,
    input logic         right_o,
    input logic         valid_o,
    input logic         err_o
);
    // R9: valid is a single-cycle pulse
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst || sw_rst)
        valid_o |=> !valid_o);

    // R9: word and tag hold between pulses
    a_r9_hold: assert property (@(posedge clk) disable iff (rst || sw_rst)
        !valid_o |-> ($stable(word_o) && $stable(right_o)));

    // R8: a dropped word never raises valid
    a_r8_err_no_valid: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o);

    // R1: soft reset clears both control bits
    a_r1_soft_clear: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (!cfg_pol_o && !cfg_rel_o));

    // R10: readback follows a write on the next cycle
    a_r10_readback: assert property (@(posedge clk) disable iff (rst || sw_rst)
        cfg_we |=> (cfg_pol_o == $past(cfg_wpol) && cfg_rel_o == $past(cfg_wrel)));
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sw_rst    (sw_rst),
    .cfg_we    (cfg_we),
    .cfg_wpol  (cfg_wpol),
    .cfg_wrel  (cfg_wrel),
    .cfg_pol_o (cfg_pol_o),
    .cfg_rel_o (cfg_rel_o),
    .word_o    (word_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .err_o     (err_o)
);

// File: tb/sim_aud_ser_rx.sv
`timescale 1ns/1ps
module sim_aud_ser_rx;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_rst = 1'b0;
    logic cfg_we = 1'b0, cfg_wpol = 1'b0, cfg_wrel = 1'b0;
    logic cfg_pol_o, cfg_rel_o;
    logic sclk_r = 1'b0, ws_r = 1'b0, sd_r = 1'b0;
    logic [W-1:0] word_o;
    logic right_o, valid_o, err_o;

    always #4 clk = ~clk;   // 125 MHz

    aud_ser_rx #(.W(W)) u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst),
        .cfg_we(cfg_we), .cfg_wpol(cfg_wpol), .cfg_wrel(cfg_wrel),
        .cfg_pol_o(cfg_pol_o), .cfg_rel_o(cfg_rel_o),
        .sclk_i(sclk_r), .ws_i(ws_r), .sd_i(sd_r),
        .word_o(word_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // stream of bits to send: channel and data per bit
    logic ch_a [0:127];
    logic d_a  [0:127];
    int   n = 0;

    // captured output
    logic [W-1:0] cap_w [0:15];
    logic         cap_r [0:15];
    int ncap = 0, nerr = 0, hold_bad = 0;
    logic [W-1:0] last_w = '0;
    logic         last_r = 1'b0;

    always @(negedge clk) begin
        if (!rst && !sw_rst) begin
            if (valid_o) begin
                if (ncap < 16) begin
                    cap_w[ncap] = word_o;
                    cap_r[ncap] = right_o;
                end
                ncap++;
                last_w = word_o;
                last_r = right_o;
            end else if (ncap > 0 && (word_o != last_w || right_o != last_r)) begin
                hold_bad++;
            end
            if (err_o) nerr++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sclk_r = 1'b0; ws_r = 1'b0; sd_r = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ncap = 0; nerr = 0; hold_bad = 0; n = 0;
        last_w = '0; last_r = 1'b0;
    endtask

    task automatic wcfg(input logic p, input logic r);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wpol = p; cfg_wrel = r;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_word(input logic ch, input logic [31:0] val, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            ch_a[n] = ch;
            d_a[n]  = val[i];
            n++;
        end
    endtask

    // one bit: change edge, lines update a cycle later, then sampling edge
    task automatic send_bit(input logic p, input logic w, input logic d);
        @(negedge clk);
        sclk_r = p;
        @(negedge clk);
        ws_r = w; sd_r = d;
        repeat (3) @(negedge clk);
        sclk_r = ~p;
        repeat (4) @(negedge clk);
    endtask

    // play the stream; drive polarity p1 from bit sw_idx on; write cfg at bit wr_idx
    task automatic play(input logic rel, input logic p0, input logic p1, input int sw_idx,
                        input int wr_idx, input logic np, input logic nr);
        for (int k = 0; k < n; k++) begin
            logic wsv;
            if (k == wr_idx) wcfg(np, nr);
            wsv = (rel && k + 1 < n) ? ch_a[k+1] : ch_a[k];
            send_bit((k >= sw_idx) ? p1 : p0, wsv, d_a[k]);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(cfg_pol_o == 1'b0, "R1 pol after reset", cfg_pol_o, 0);
        chk(cfg_rel_o == 1'b0, "R1 rel after reset", cfg_rel_o, 0);
        chk(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
        chk(err_o == 1'b0, "R1 err after reset", err_o, 0);
    endtask

    task automatic t_frame(input logic p, input logic r, input string req);
        logic [W-1:0] lv, rv;
        lv = 24'hA5C3F0;
        rv = 24'h3C5A96 ^ {21'd0, p, r, 1'b1};
        do_reset();
        wcfg(p, r);
        repeat (4) @(negedge clk);
        push_word(1'b1, 32'h5, 3);
        push_word(1'b0, 32'(lv), W);
        push_word(1'b1, 32'(rv), W);
        play(r, p, p, 999, -1, 1'b0, 1'b0);
        chk(ncap == 2, {req, " word count"}, ncap, 2);
        chk(cap_w[0] == lv, {req, " left data"}, cap_w[0], lv);
        chk(cap_r[0] == 1'b0, {req, " R6 left tag"}, cap_r[0], 0);
        chk(cap_w[1] == rv, {req, " right data"}, cap_w[1], rv);
        chk(cap_r[1] == 1'b1, {req, " R6 right tag"}, cap_r[1], 1);
        chk(nerr == 0, {req, " no error"}, nerr, 0);
        chk(hold_bad == 0, "R9 hold between pulses", hold_bad, 0);
    endtask

    task automatic t_idle();
        do_reset();
        for (int k = 0; k < 40; k++) push_word(1'b0, 32'(k & 1), 1);
        play(1'b0, 1'b0, 1'b0, 999, -1, 1'b0, 1'b0);
        chk(ncap == 0, "R11 no word before first transition", ncap, 0);
        chk(nerr == 0, "R11 no error before first transition", nerr, 0);
    endtask

    task automatic t_short();
        do_reset();
        push_word(1'b1, 32'h3, 3);
        push_word(1'b0, 32'h2B5, 10);
        push_word(1'b1, 32'h00F00D, W);
        push_word(1'b0, 32'h123456, W);
        play(1'b0, 1'b0, 1'b0, 999, -1, 1'b0, 1'b0);
        chk(nerr == 1, "R8 one error for short word", nerr, 1);
        chk(ncap == 2, "R8 short word dropped", ncap, 2);
        chk(cap_w[0] == 24'h00F00D && cap_r[0] == 1'b1, "R8 next word intact", cap_w[0], 24'h00F00D);
    endtask

    task automatic t_long();
        logic [25:0] v;
        v = 26'h2ABCDEF;
        do_reset();
        push_word(1'b1, 32'h1, 3);
        push_word(1'b0, 32'(v), 26);
        push_word(1'b1, 32'h987654, W);
        play(1'b0, 1'b0, 1'b0, 999, -1, 1'b0, 1'b0);
        chk(ncap == 2, "R7 long slot word count", ncap, 2);
        chk(cap_w[0] == v[25:2], "R7 extra bits ignored", cap_w[0], v[25:2]);
        chk(cap_w[1] == 24'h987654, "R7 following word", cap_w[1], 24'h987654);
        chk(nerr == 0, "R7 no error on long slot", nerr, 0);
    endtask

    task automatic t_defer();
        do_reset();
        push_word(1'b1, 32'h6, 3);
        push_word(1'b0, 32'hC0FFEE, W);
        push_word(1'b1, 32'h5EA1ED, W);
        push_word(1'b0, 32'h0BEEF1, W);
        // write polarity 1 inside the left word; drive it from the bit after the right MSB
        play(1'b0, 1'b0, 1'b1, 3 + W + 1, 8, 1'b1, 1'b0);
        chk(cfg_pol_o == 1'b1, "R10 readback of written pol", cfg_pol_o, 1);
        chk(ncap == 3, "R10 word count across change", ncap, 3);
        chk(cap_w[0] == 24'hC0FFEE, "R10 word in progress unharmed", cap_w[0], 24'hC0FFEE);
        chk(cap_w[1] == 24'h5EA1ED, "R10 new edge after boundary", cap_w[1], 24'h5EA1ED);
        chk(cap_w[2] == 24'h0BEEF1, "R10 later word", cap_w[2], 24'h0BEEF1);
    endtask

    task automatic t_soft();
        do_reset();
        wcfg(1'b1, 1'b1);
        @(negedge clk);
        chk(cfg_pol_o && cfg_rel_o, "R10 readback both set", {cfg_pol_o, cfg_rel_o}, 3);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        @(negedge clk);
        chk(!cfg_pol_o && !cfg_rel_o, "R1 soft reset clears control", {cfg_pol_o, cfg_rel_o}, 0);
        chk(!valid_o && !err_o, "R1 soft reset clears strobes", {valid_o, err_o}, 0);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_frame(1'b0, 1'b0, "R2 R4");
        t_frame(1'b1, 1'b0, "R3");
        t_frame(1'b0, 1'b1, "R5");
        t_frame(1'b1, 1'b1, "R3 R5");
        t_idle();
        t_short();
        t_long();
        t_defer();
        t_soft();
        done = 1'b1;
        finish_sim();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_sim();
        end
    end
endmodule